// File: doc/BRIEF.md
# Dual Repeating Code Detector

This block watches a received serial bitstream for two repeating bit patterns at the same time: a loop-up code and a loop-down code. Each pattern is held in its own 8-bit code input and has its own 3-bit length select, so either pattern can be anywhere from 1 to 8 bits long. A bit strobe marks the cycles that carry a received bit. A frame-bit flag marks the bits that belong to the framing overhead. When framed operation is enabled, those bits are left out of the comparison. When it is disabled, the stream is treated as unframed and every strobed bit counts.

Detection works over a fixed integration window that is counted in accepted bits. The default window is 74112 bits, which is about 48 ms of a 1.544 Mb/s line. Within each window, every possible alignment of each pattern keeps its own mismatch count, so the receiver never has to find the pattern phase first. When the window closes, a detector declares its code present if at least one alignment stayed at or below an error threshold. The default threshold is 1482 bits, about 2% of the window, which lets detection ride through a bit error rate of 1e-2. Two sticky status flags report the result, and a clear strobe resets them. The next window starts directly after each one closes.

Top module: `loop_code_detector`

## Requirements
- R1: While rst_n is low at a clock edge, both status flags go to 0 and the accepted-bit window count returns to 0. The first window after reset closes on the WINDOW_BITS-th accepted bit that follows.
- R2: A length select value s (0..7) selects a pattern of s+1 bits. Those bits are taken most significant bit first, so pattern bit j is code[7-j]. The up detector uses up_code/up_len and the down detector uses dn_code/dn_len.
- R3: A bit is accepted only when bit_valid is 1 and not (framed_en and fbit_pos). Cycles with bit_valid at 0 have no effect on the window count or on detection. A window closes on exactly the WINDOW_BITS-th accepted bit.
- R4: A detector whose pattern alignment has at most MAX_ERR mismatches in a window sets its flag. The flag is visible in the cycle after the edge that accepts the window's last bit.
- R5: Detection does not depend on where the repeating pattern starts relative to the window; any rotation of the pattern is found.
- R6: If every alignment of a detector has more than MAX_ERR mismatches in a window, that window does not set the flag.
- R7: With framed_en at 1, bits flagged by fbit_pos are skipped and do not break detection. With framed_en at 0, such bits are compared like any other bit.
- R8: The flags are sticky. A set flag holds through later windows without the code, and drops one cycle after a clear pulse in a cycle that does not close a detecting window.
- R9: When clear is high in the cycle where a window closes with a detection, the flag is set. The set takes priority over the clear.
- R10: The two detectors are independent. Each flag reflects only its own code and length, even when both codes hold the same register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | A received bit is present on rx_bit |
| rx_bit | input | 1 | Received serial data bit |
| fbit_pos | input | 1 | Current bit is in the frame-bit position |
| framed_en | input | 1 | Skip frame-bit positions when 1 |
| up_code | input | 8 | Loop-up pattern, MSB first |
| up_len | input | 3 | Loop-up length select (value+1 bits) |
| dn_code | input | 8 | Loop-down pattern, MSB first |
| dn_len | input | 3 | Loop-down length select (value+1 bits) |
| clear | input | 1 | Clears both status flags |
| up_det | output | 1 | Sticky loop-up detected flag |
| dn_det | output | 1 | Sticky loop-down detected flag |

## Verification
Two functions can land in the same cycle: the window closing with a detection, and a clear pulse. The bench holds clear high on the very strobe that carries the last accepted bit of a clean loop-up window. It then expects up_det to read 1 afterwards, because the set must win. A following lone clear must drop the flag, which shows that the surviving 1 came from the set and not from a clear that was ignored.

// File: rtl/lcd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the dual repeating code detector.
// Assumes codes are 8 bits wide and lengths are encoded as value+1.
package lcd_pkg;
    localparam int CODE_W   = 8;
    localparam int LEN_SEL_W = 3;
    localparam int NUM_DET  = 2;

    // Converts a length select into a pattern length of 1..8.
    function automatic logic [3:0] len_of(input logic [LEN_SEL_W-1:0] sel);
        return {1'b0, sel} + 4'd1;
    endfunction
endpackage

// File: rtl/lcd_window_ctrl.sv
`timescale 1ns/1ps
// Module: lcd_window_ctrl
// Qualifies incoming bit strobes and counts accepted bits into fixed
// integration windows. It marks the accepted bit that closes each window.
// Assumes WINDOW_BITS >= 2.
module lcd_window_ctrl #(
    parameter int WINDOW_BITS = 74112,
    localparam int CNT_W = $clog2(WINDOW_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             fbit_pos,
    input  logic             framed_en,
    output logic             accept,
    output logic             win_end,
    output logic [CNT_W-1:0] win_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_BITS - 1);

    // Decides whether this strobe carries a payload bit.
    always_comb begin
        accept  = bit_valid && !(framed_en && fbit_pos);
        win_end = accept && (win_cnt == LAST);
    end

    // Counts accepted bits and wraps when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (accept) begin
            if (win_end) win_cnt <= '0;
            else         win_cnt <= win_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lcd_phase_matcher.sv
`timescale 1ns/1ps
// Module: lcd_phase_matcher
// Compares each accepted bit against every rotation of one programmed
// pattern at once. It keeps a saturating mismatch count per rotation and
// reports a hit at window close when any valid rotation stayed within
// MAX_ERR. Assumes the window controller supplies accept and win_end.
module lcd_phase_matcher
    import lcd_pkg::*;
#(
    parameter int MAX_ERR = 1482,
    localparam int ERR_CAP = MAX_ERR + 1,
    localparam int ERR_W = $clog2(ERR_CAP + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 win_end,
    input  logic                 rx_bit,
    input  logic [CODE_W-1:0]    code,
    input  logic [LEN_SEL_W-1:0] len_sel,
    output logic                 window_hit
);
    logic [3:0]        n_len;
    logic [2:0]        ref_idx;
    logic [CODE_W-1:0] phase_ok;

    // Decodes the selected pattern length.
    always_comb n_len = len_of(len_sel);

    // Steps the reference position through the pattern on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_idx <= '0;
        end else if (accept) begin
            if ({1'b0, ref_idx} >= n_len - 4'd1) ref_idx <= '0;
            else                                 ref_idx <= ref_idx + 3'd1;
        end
    end

    for (genvar p = 0; p < CODE_W; p++) begin : g_phase
        logic [3:0]       pos;
        logic             exp_bit;
        logic [ERR_W-1:0] err_q;
        logic [ERR_W-1:0] err_next;

        // Finds the pattern bit this rotation expects now and its new error count.
        always_comb begin
            pos     = ({1'b0, ref_idx} + 4'(p)) % n_len;
            exp_bit = |(code & (8'h80 >> pos));
            if (err_q == ERR_W'(ERR_CAP)) err_next = err_q;
            else                          err_next = err_q + ERR_W'(exp_bit ^ rx_bit);
            phase_ok[p] = (4'(p) < n_len) && (err_next <= ERR_W'(MAX_ERR));
        end

        // Holds this rotation's mismatch count for the open window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_q <= '0;
            end else if (accept) begin
                if (win_end) err_q <= '0;
                else         err_q <= err_next;
            end
        end
    end

    // Reports a detection only on the closing bit of a window.
    always_comb window_hit = win_end && (|phase_ok);
endmodule

// File: rtl/lcd_sticky_flag.sv
`timescale 1ns/1ps
// Module: lcd_sticky_flag
// A status bit that sets on a hit and clears on a clear pulse. A set in the
// same cycle as a clear wins.
module lcd_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic flag
);
    // Updates the sticky bit with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end
endmodule

// File: rtl/loop_code_detector.sv
`timescale 1ns/1ps
// Module: loop_code_detector
// Top of the dual repeating code detector. One shared window controller
// feeds two pattern matchers (index 0 for loop-up, index 1 for loop-down),
// and each matcher drives its own sticky flag.
// Assumes one bit at most per clock, marked by bit_valid.
module loop_code_detector
    import lcd_pkg::*;
#(
    parameter int WINDOW_BITS = 74112,
    parameter int MAX_ERR = 1482,
    localparam int CNT_W = $clog2(WINDOW_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_valid,
    input  logic                 rx_bit,
    input  logic                 fbit_pos,
    input  logic                 framed_en,
    input  logic [CODE_W-1:0]    up_code,
    input  logic [LEN_SEL_W-1:0] up_len,
    input  logic [CODE_W-1:0]    dn_code,
    input  logic [LEN_SEL_W-1:0] dn_len,
    input  logic                 clear,
    output logic                 up_det,
    output logic                 dn_det
);
    logic                                 accept;
    logic                                 win_end;
    logic [CNT_W-1:0]                     win_cnt;
    logic [NUM_DET-1:0][CODE_W-1:0]       code_arr;
    logic [NUM_DET-1:0][LEN_SEL_W-1:0]    len_arr;
    logic [NUM_DET-1:0]                   hit;
    logic [NUM_DET-1:0]                   det;

    // Gathers the per-detector settings into indexed arrays.
    always_comb begin
        code_arr = {dn_code, up_code};
        len_arr  = {dn_len, up_len};
        up_det   = det[0];
        dn_det   = det[1];
    end

    lcd_window_ctrl #(.WINDOW_BITS(WINDOW_BITS)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .fbit_pos  (fbit_pos),
        .framed_en (framed_en),
        .accept    (accept),
        .win_end   (win_end),
        .win_cnt   (win_cnt)
    );

    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
        lcd_phase_matcher #(.MAX_ERR(MAX_ERR)) u_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .accept     (accept),
            .win_end    (win_end),
            .rx_bit     (rx_bit),
            .code       (code_arr[d]),
            .len_sel    (len_arr[d]),
            .window_hit (hit[d])
        );

        lcd_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (hit[d]),
            .clear (clear),
            .flag  (det[d])
        );
    end
endmodule

// File: rtl/lcd_checker.sv
`timescale 1ns/1ps
// Module: lcd_checker
// Temporal properties of the detector, bound to the top module.
module lcd_checker #(
    parameter int WINDOW_BITS = 74112,
    localparam int CNT_W = $clog2(WINDOW_BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             accept,
    input logic             win_end,
    input logic [CNT_W-1:0] win_cnt,
    input logic             up_det,
    input logic             dn_det
);
    // R1: reset empties flags and window.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!up_det && !dn_det && win_cnt == '0));

    // R3: the window count never reaches the window length.
    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(win_cnt) < WINDOW_BITS);

    // R3: cycles without an accepted bit leave the window alone.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(win_cnt));

    // R3: a closing bit restarts the window.
    p_close_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> win_cnt == '0);

    // R4: flags rise only after a window close.
    p_up_rise_at_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_det) |-> $past(win_end));
    p_dn_rise_at_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_det) |-> $past(win_end));

    // R8: a set flag holds until a clear.
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_det && !clear) |=> up_det);

    // R8: a clear outside a window close drops both flags.
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !win_end) |=> (!up_det && !dn_det));
endmodule

bind loop_code_detector lcd_checker #(.WINDOW_BITS(WINDOW_BITS)) i_lcd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .accept  (accept),
    .win_end (win_end),
    .win_cnt (win_cnt),
    .up_det  (up_det),
    .dn_det  (dn_det)
);

// File: tb/test_loop_code_detector.sv
`timescale 1ns/1ps
module test_loop_code_detector;
    localparam int W = 40;
    localparam int E = 1;

    typedef struct packed {
        logic [7:0] upc;
        logic [2:0] upl;
        logic [7:0] dnc;
        logic [2:0] dnl;
        logic [1:0] src;   // 0 up pattern, 1 down pattern, 2 all zeros
        logic [2:0] off;
        logic [1:0] nerr;
        logic       fins;  // insert frame-bit slots
        logic       fen;   // framed_en value
        logic       eup;
        logic       edn;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd0, 3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd0, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd1, 3'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd1, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'h80, 3'd4, 8'h80, 3'd1, 2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h00, 3'd0, 8'h96, 3'd7, 2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h00, 3'd0, 8'h96, 3'd7, 2'd1, 3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       fbit_pos = 1'b0;
    logic       framed_en = 1'b0;
    logic [7:0] up_code = 8'h80;
    logic [2:0] up_len = 3'd4;
    logic [7:0] dn_code = 8'h80;
    logic [2:0] dn_len = 3'd1;
    logic       clear = 1'b0;
    logic       up_det;
    logic       dn_det;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    loop_code_detector #(.WINDOW_BITS(W), .MAX_ERR(E)) i_loop_code_detector (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .fbit_pos(fbit_pos), .framed_en(framed_en), .up_code(up_code),
        .up_len(up_len), .dn_code(dn_code), .dn_len(dn_len), .clear(clear),
        .up_det(up_det), .dn_det(dn_det)
    );

    function automatic logic pat_bit(input logic [7:0] c, input logic [2:0] l, input int idx);
        int n = int'(l) + 1;
        return c[7 - (idx % n)];
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Sends 'count' accepted bits of a source pattern, with idle and optional frame slots.
    task automatic run_bits(input logic [7:0] c, input logic [2:0] l, input int off,
                            input int start, input int count, input int nerr,
                            input bit fins, input bit fen, input bit clr_last);
        int acc = 0;
        int i = start;
        int k = 0;
        framed_en = fen;
        while (acc < count) begin
            k++;
            @(negedge clk);
            clear = 1'b0;
            fbit_pos = 1'b0;
            if (k % 4 == 0) begin
                bit_valid = 1'b0;
                rx_bit = ~pat_bit(c, l, i + off);
            end else if (fins && (k % 7 == 3)) begin
                bit_valid = 1'b1;
                fbit_pos = 1'b1;
                rx_bit = ~pat_bit(c, l, i + off);
                if (!fen) acc++;
            end else begin
                bit_valid = 1'b1;
                rx_bit = pat_bit(c, l, i + off) ^ ((i == 6 && nerr >= 1) || (i == 21 && nerr >= 2));
                i++;
                acc++;
                if (clr_last && acc == count) clear = 1'b1;
            end
        end
        @(negedge clk);
        bit_valid = 1'b0;
        fbit_pos = 1'b0;
        clear = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear = 1'b1;
        bit_valid = 1'b0;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(up_det, 1'b0, "R1 up_det after reset");
        check(dn_det, 1'b0, "R1 dn_det after reset");
        rst_n = 1'b1;

        // Table walk: R2 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            logic [7:0] sc;
            logic [2:0] sl;
            up_code = VECS[v].upc; up_len = VECS[v].upl;
            dn_code = VECS[v].dnc; dn_len = VECS[v].dnl;
            case (VECS[v].src)
                2'd0:    begin sc = VECS[v].upc; sl = VECS[v].upl; end
                2'd1:    begin sc = VECS[v].dnc; sl = VECS[v].dnl; end
                default: begin sc = 8'h00;       sl = 3'd0;        end
            endcase
            pulse_clear();
            run_bits(sc, sl, int'(VECS[v].off), 0, W, int'(VECS[v].nerr),
                     VECS[v].fins, VECS[v].fen, 1'b0);
            check(up_det, VECS[v].eup, $sformatf("R4 R5 R6 R7 R10 R2 up vector %0d", v));
            check(dn_det, VECS[v].edn, $sformatf("R4 R5 R6 R7 R10 R2 dn vector %0d", v));
        end

        // R8: sticky through a window without the code
        up_code = 8'h80; up_len = 3'd4; dn_code = 8'h80; dn_len = 3'd1;
        run_bits(8'h00, 3'd0, 0, 0, W, 0, 1'b0, 1'b0, 1'b0);
        check(dn_det, 1'b1, "R8 dn holds without clear");
        check(up_det, 1'b0, "R8 up stays low on zeros");
        pulse_clear();
        check(dn_det, 1'b0, "R8 clear drops dn");

        // R9: clear on the closing bit of a detecting window
        run_bits(8'h80, 3'd4, 2, 0, W, 0, 1'b0, 1'b0, 1'b1);
        check(up_det, 1'b1, "R9 set wins over clear");
        pulse_clear();
        check(up_det, 1'b0, "R9 later clear drops up");

        // R1 R3: reset mid-window restarts the count
        run_bits(8'h00, 3'd0, 0, 0, 20, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(up_det, 1'b0, "R1 up low in reset");
        rst_n = 1'b1;
        run_bits(8'h80, 3'd4, 0, 0, W - 1, 0, 1'b0, 1'b0, 1'b0);
        check(up_det, 1'b0, "R3 window still open after W-1 bits");
        run_bits(8'h80, 3'd4, 0, W - 1, 1, 0, 1'b0, 1'b0, 1'b0);
        check(up_det, 1'b1, "R3 R4 window closes on bit W");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule